// File: doc/BRIEF.md
# Single-Byte Bus Handshake Engine

This block performs the target side of the asynchronous request/acknowledge handshake on a parallel peripheral bus, one byte at a time. A start strobe with a direction bit launches one transfer. For a transfer to the host, the block drives the byte and its parity, lets the bus settle for a fixed setup time, raises REQ and waits for the host's ACK. It then releases REQ and the data bus together and waits for ACK to go away. For a transfer from the host, it raises REQ, waits for ACK, lets the data settle, samples the byte with its parity bit, drops REQ and waits for ACK to go away.

ACK from the host is asynchronous to the block clock. The level is synchronized. During a transfer to the host, an asynchronous latch also records the assertion edge of ACK, so a pulse shorter than one clock period is still counted. A bus-reset flag ends any transfer in progress at once. The block reports completion with a one-cycle done pulse. All bus signals are logical active-high; the pad polarity is handled outside the block.

Top module: `hs_byte_engine`

## Requirements
- R1: In a transfer to the host, db_o carries the byte and dbp_o its odd parity (dbp_o = ~^byte), with db_oe_o high, for exactly SETUP_CYC = ceil(SETUP_NS / CLK_PERIOD_NS) clock cycles before req_o rises.
- R2: In a transfer to the host, an ACK pulse shorter than one clock period that arrives while req_o is high counts as an acknowledge. An ACK pulse that arrives during the setup time, before req_o rises, is discarded.
- R3: When ACK is recognised in a transfer to the host, req_o and db_oe_o fall in the same cycle. done_o does not pulse while ACK is still asserted.
- R4: In a transfer from the host, db_oe_o stays low, and req_o stays high for SYNC_STAGES + SETUP_CYC cycles after ACK rises. db_i and dbp_i are sampled into rd_byte_o in the cycle in which req_o falls.
- R5: In a transfer from the host, done_o pulses only after ACK has deasserted following the fall of req_o.
- R6: A received byte fails parity when the 9-bit XOR of db_i and dbp_i is 0. A failure sets perr_o, which stays set across later good bytes until rst_ni is asserted.
- R7: bus_rst_i high during any busy cycle makes the next cycle idle: busy_o, req_o and db_oe_o are low, and done_o and abort_o are high for one cycle.
- R8: busy_o is high from the cycle after an accepted start until done_o. A start_i strobe seen while busy_o is high is ignored and launches no later transfer.
- R9: While rst_ni is low, req_o, db_oe_o, busy_o, done_o, abort_o and perr_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one byte transfer (taken only when idle) |
| rd_i | input | 1 | Direction: 1 = from host, 0 = to host |
| wr_byte_i | input | DW | Byte to send to the host |
| bus_rst_i | input | 1 | Bus reset flag, aborts a transfer |
| ack_i | input | 1 | Host acknowledge, asynchronous |
| db_i | input | DW | Data bus input |
| dbp_i | input | 1 | Data bus parity input |
| req_o | output | 1 | Target request |
| db_o | output | DW | Data bus output |
| dbp_o | output | 1 | Data bus parity output |
| db_oe_o | output | 1 | Data bus output enable |
| rd_byte_o | output | DW | Last byte received from the host |
| perr_o | output | 1 | Sticky parity error |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| abort_o | output | 1 | Qualifies done_o: transfer ended by bus reset |

## Verification
The bench builds the engine with a 10 ns clock period, SETUP_NS = 55 and two synchronizer stages. The setup time of 55 ns therefore rounds up to six cycles, which checks the rounding in the derived count. It also keeps the setup window longer than the synchronizer. That makes it possible to place an ACK pulse of a few nanoseconds between clock edges, both inside the setup window and while REQ is high, and to count exactly how many cycles REQ stays up after ACK rises.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WREQ,
    ST_WREL,
    ST_RREQ,
    ST_RHOLD,
    ST_RREL
  } hs_state_e;

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hs_edge_latch.sv
// Records a rising edge of an asynchronous strobe until cleared.
module hs_edge_latch (
  input  logic strobe_i,
  input  logic clr_i,
  input  logic rst_ni,
  output logic q_o
);
  always_ff @(posedge strobe_i or posedge clr_i or negedge rst_ni)
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= 1'b1;
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wr_byte_i,
  input  logic          bus_rst_i,
  input  logic          ack_s_i,
  input  logic          edge_s_i,
  input  logic [DW-1:0] db_i,
  input  logic          dbp_i,
  output logic          edge_clr_o,
  output logic          req_o,
  output logic [DW-1:0] db_o,
  output logic          dbp_o,
  output logic          db_oe_o,
  output logic [DW-1:0] rd_byte_o,
  output logic          perr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_o
);
  localparam int CW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETUP_CYC - 1);

  hs_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [DW-1:0] db_q;
  logic          dbp_q;
  logic [DW-1:0] rx_q;
  logic          perr_q, done_q, abort_q, eclr_q;
  logic          cnt_end, sample, fin, abrt;

  assign cnt_end = (cnt_q == CNT_LAST);
  assign abrt    = (st_q != ST_IDLE) && bus_rst_i;
  assign sample  = (st_q == ST_RHOLD) && cnt_end && !bus_rst_i;

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    if (abrt) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (start_i) st_d = rd_i ? ST_RREQ : ST_WSETUP;
        ST_WSETUP: if (cnt_end) st_d = ST_WREQ;
        ST_WREQ:   if (ack_s_i || edge_s_i) st_d = ST_WREL;
        ST_WREL:   if (!ack_s_i) begin st_d = ST_IDLE; fin = 1'b1; end
        ST_RREQ:   if (ack_s_i) st_d = ST_RHOLD;
        ST_RHOLD:  if (cnt_end) st_d = ST_RREL;
        ST_RREL:   if (!ack_s_i) begin st_d = ST_IDLE; fin = 1'b1; end
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      db_q    <= '0;
      dbp_q   <= 1'b0;
      rx_q    <= '0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      eclr_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      done_q  <= fin || abrt;
      abort_q <= abrt;
      // edge latch armed only while REQ waits for ACK in a write
      eclr_q  <= (st_d != ST_WREQ);
      if (st_d != st_q) cnt_q <= '0;
      else if (!cnt_end) cnt_q <= cnt_q + 1'b1;
      if (st_q == ST_IDLE && start_i) begin
        rd_q <= rd_i;
        if (!rd_i) begin
          db_q  <= wr_byte_i;
          dbp_q <= odd_par(wr_byte_i);
        end
      end
      if (sample) begin
        rx_q <= db_i;
        if (!(^{db_i, dbp_i})) perr_q <= 1'b1;
      end
    end
  end

  assign edge_clr_o = eclr_q;
  assign req_o      = (st_q == ST_WREQ) || (st_q == ST_RREQ) || (st_q == ST_RHOLD);
  assign db_oe_o    = (st_q == ST_WSETUP) || (st_q == ST_WREQ);
  assign db_o       = db_q;
  assign dbp_o      = dbp_q;
  assign rd_byte_o  = rx_q;
  assign perr_o     = perr_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign abort_o    = abort_q;

  AST_WR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && !rd_q) |-> ($past(db_oe_o) && $stable(db_o))); // R1
  AST_DONE_ACK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !abort_o) |-> !ack_s_i); // R5
  AST_PERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(perr_o) |-> perr_o); // R6
  AST_BUS_RST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bus_rst_i) |=> (!busy_o && !req_o && done_o && abort_o)); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(rd_q)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
endmodule

// File: rtl/hs_byte_engine.sv
module hs_byte_engine #(
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETUP_NS      = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wr_byte_i,
  input  logic          bus_rst_i,
  input  logic          ack_i,
  input  logic [DW-1:0] db_i,
  input  logic          dbp_i,
  output logic          req_o,
  output logic [DW-1:0] db_o,
  output logic          dbp_o,
  output logic          db_oe_o,
  output logic [DW-1:0] rd_byte_o,
  output logic          perr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_o
);
  localparam int SETUP_RAW = (SETUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;

  logic ack_s, edge_raw, edge_s, edge_clr;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  hs_edge_latch u_ack_edge (
    .strobe_i(ack_i), .clr_i(edge_clr), .rst_ni(rst_ni), .q_o(edge_raw)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_edge_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(edge_raw), .q_o(edge_s)
  );

  hs_ctrl #(.DW(DW), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .wr_byte_i  (wr_byte_i),
    .bus_rst_i  (bus_rst_i),
    .ack_s_i    (ack_s),
    .edge_s_i   (edge_s),
    .db_i       (db_i),
    .dbp_i      (dbp_i),
    .edge_clr_o (edge_clr),
    .req_o      (req_o),
    .db_o       (db_o),
    .dbp_o      (dbp_o),
    .db_oe_o    (db_oe_o),
    .rd_byte_o  (rd_byte_o),
    .perr_o     (perr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .abort_o    (abort_o)
  );
endmodule

// File: tb/sim_hs_byte_engine.sv
`timescale 1ns/1ps
module sim_hs_byte_engine;
  localparam int S = 6;  // ceil(55/10)
  localparam int Y = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0, bus_rst_i = 1'b0, ack_i = 1'b0, dbp_i = 1'b0;
  logic [7:0] wr_byte_i = '0, db_i = '0;
  logic req_o, dbp_o, db_oe_o, perr_o, busy_o, done_o, abort_o;
  logic [7:0] db_o, rd_byte_o;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  hs_byte_engine #(.DW(8), .CLK_PERIOD_NS(10), .SETUP_NS(55), .SYNC_STAGES(Y)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i),
    .wr_byte_i(wr_byte_i), .bus_rst_i(bus_rst_i), .ack_i(ack_i), .db_i(db_i),
    .dbp_i(dbp_i), .req_o(req_o), .db_o(db_o), .dbp_o(dbp_o), .db_oe_o(db_oe_o),
    .rd_byte_o(rd_byte_o), .perr_o(perr_o), .busy_o(busy_o), .done_o(done_o),
    .abort_o(abort_o)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 100 && !req_o; i++) @(negedge clk);
  endtask

  task automatic wait_done(output bit got, output bit ab);
    got = 1'b0; ab = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done_o) begin got = 1'b1; ab = abort_o; break; end
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_o && !db_oe_o && !busy_o && !done_o && !abort_o && !perr_o, "R9", "outputs in reset",
        {req_o, db_oe_o, busy_o, done_o, abort_o, perr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // send one byte to the host; short = sub-cycle ACK pulse
  task automatic t_write(input logic [7:0] b, input bit short, input bit stale);
    int n = 0;
    bit got, ab;
    start_i = 1'b1; rd_i = 1'b0; wr_byte_i = b;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (i == 0) chk(busy_o, "R8", "busy after start", busy_o, 1);
      if (req_o) break;
      if (db_oe_o) n++;
      if (stale && i == 1) begin #1 ack_i = 1'b1; #2 ack_i = 1'b0; end
    end
    chk(n == S, "R1", "setup cycles", n, S);
    chk(db_o == b && db_oe_o, "R1", "data driven", db_o, b);
    chk(dbp_o == ~^b, "R1", "odd parity out", dbp_o, ~^b);
    if (stale) begin
      repeat (5) @(negedge clk);
      chk(req_o, "R2", "early ACK pulse discarded", req_o, 1);
    end
    if (short) begin
      #1 ack_i = 1'b1; #2 ack_i = 1'b0;
    end else ack_i = 1'b1;
    for (int i = 0; i < 100 && req_o; i++) @(negedge clk);
    chk(!req_o && !db_oe_o, "R3", "REQ and bus released together", {req_o, db_oe_o}, 0);
    if (!short) begin
      repeat (4) @(negedge clk);
      chk(busy_o && !done_o, "R3", "no done while ACK held", done_o, 0);
      ack_i = 1'b0;
    end
    wait_done(got, ab);
    chk(got && !ab, short ? "R2" : "R3", "write completes", got, 1);
  endtask

  task automatic t_read(input logic [7:0] b, input logic p, input bit exp_perr);
    int n = 0;
    bit got, ab;
    start_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_req();
    chk(req_o && !db_oe_o, "R4", "REQ up, bus not driven", {req_o, db_oe_o}, 2);
    db_i = b; dbp_i = p; ack_i = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_o) n++; else break;
    end
    chk(n == Y + S, "R4", "REQ hold after ACK", n, Y + S);
    chk(rd_byte_o == b, "R4", "sampled byte", rd_byte_o, b);
    chk(perr_o == exp_perr, "R6", "parity flag", perr_o, exp_perr);
    db_i = 8'hxx;
    repeat (3) @(negedge clk);
    chk(busy_o && !done_o, "R5", "no done while ACK held", done_o, 0);
    ack_i = 1'b0;
    wait_done(got, ab);
    chk(got && !ab, "R5", "read completes", got, 1);
    chk(rd_byte_o == b, "R4", "byte held", rd_byte_o, b);
  endtask

  task automatic t_ignore();
    bit oe_seen = 1'b0, got, ab;
    start_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; rd_i = 1'b0; wr_byte_i = 8'hA5;  // should be ignored
    @(negedge clk);
    start_i = 1'b0;
    wait_req();
    ack_i = 1'b1;
    for (int i = 0; i < 100 && req_o; i++) begin
      @(negedge clk);
      if (db_oe_o) oe_seen = 1'b1;
    end
    ack_i = 1'b0;
    wait_done(got, ab);
    repeat (4) begin
      @(negedge clk);
      if (db_oe_o || busy_o) oe_seen = 1'b1;
    end
    chk(got && !oe_seen, "R8", "start while busy ignored", oe_seen, 0);
  endtask

  task automatic t_abort(input bit rd);
    start_i = 1'b1; rd_i = rd; wr_byte_i = 8'h3C;
    @(negedge clk);
    start_i = 1'b0;
    wait_req();
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
    chk(!busy_o && !req_o && !db_oe_o && done_o && abort_o, "R7",
        rd ? "abort read" : "abort write",
        {busy_o, req_o, db_oe_o, done_o, abort_o}, 3);
    @(negedge clk);
    chk(!done_o && !abort_o, "R7", "abort pulse one cycle", {done_o, abort_o}, 0);
  endtask

  initial begin
    t_reset();
    t_write(8'h5A, 1'b0, 1'b0);
    t_write(8'h01, 1'b1, 1'b0);
    t_write(8'hF0, 1'b0, 1'b1);
    t_read(8'h96, ~^8'h96, 1'b0);
    t_read(8'h00, 1'b0, 1'b1);   // bad parity
    t_read(8'h7E, ~^8'h7E, 1'b1); // R6 stays set
    t_ignore();
    t_abort(1'b0);
    t_abort(1'b1);
    t_reset();
    chk(!perr_o, "R6", "perr cleared by reset", perr_o, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule